// File: doc/BRIEF.md
# System clock source selection and division tree

This block produces three divided system clock enables from four source clock enables. All of them share one fast clock. Each source is a one-cycle tick on that clock, asserted at the rate of the oscillator it stands for: the loop-divided clock, a 32 kHz internal reference, a crystal, and a 10 kHz internal oscillator. The outputs are single-cycle pulses at the divided rates. Logic downstream uses them as clock enables.

The main output selects one of the four sources and divides it by a power of two. The sub-main output divides the main pulses again by a power of two, and a gate control can silence it. The auxiliary output selects one of three low-frequency sources and applies a divider that also offers irregular ratios. A crystal fault moves the auxiliary output onto the 32 kHz reference unless the fault reaction is switched off. A reserved selection code is ignored. A new source or ratio is adopted only when the running output period completes.

Top module: `clk_tree_gen`

## Requirements
- R1: `main_sel_i` selects the main source: 0 = loop clock, 1 = 32 kHz reference, 2 = crystal, 3 = 10 kHz. Codes 4 to 7 are reserved.
- R2: The main output emits one pulse for every 2^`main_div_i` ticks of the selected source (/1 to /128).
- R3: The sub-main output emits one pulse for every 2^`sub_div_i` main pulses, so the two ratios multiply. Each sub-main pulse comes one cycle after the main pulse that completes its period.
- R4: While `sub_off_i` is high, `sub_tick_o` stays low.
- R5: `aux_sel_i` selects the auxiliary source: 0 = crystal, 1 = 32 kHz reference, 2 = 10 kHz. Code 3 is reserved.
- R6: `aux_div_i` codes 0 to 13 divide the auxiliary source by 1, 16, 32, 64, 128, 256, 384, 512, 768, 1024, 108, 338, 414 and 640 in that order. Codes 14 and 15 are reserved.
- R7: While `xtal_fault_i` is high and `fault_off_i` is low, an auxiliary path set to the crystal counts 32 kHz reference ticks instead. With `fault_off_i` high, or with another auxiliary source, the fault has no effect.
- R8: A reserved code on `main_sel_i`, `aux_sel_i` or `aux_div_i` leaves the last valid value of that field in force.
- R9: A change of source or ratio takes effect only when the current output period ends with a pulse, or while the divider sits idle at the start of a period. No output period is cut short.
- R10: Every output is high for exactly one cycle per period. A main or auxiliary pulse appears one cycle after the source tick that completes the period. During and after reset, with no source ticks, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock shared by all sources |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_tick_i | input | 1 | Loop-divided clock tick |
| ref32_tick_i | input | 1 | 32 kHz reference tick |
| xtal_tick_i | input | 1 | Crystal clock tick |
| lf10_tick_i | input | 1 | 10 kHz oscillator tick |
| main_sel_i | input | 3 | Main source code |
| main_div_i | input | 3 | Main divide exponent |
| sub_div_i | input | 2 | Sub-main divide exponent |
| sub_off_i | input | 1 | Sub-main gate off |
| aux_sel_i | input | 2 | Auxiliary source code |
| aux_div_i | input | 4 | Auxiliary ratio code |
| xtal_fault_i | input | 1 | Crystal fault indication |
| fault_off_i | input | 1 | Disables the fault-driven auxiliary switch |
| main_tick_o | output | 1 | Main clock enable pulse |
| sub_tick_o | output | 1 | Sub-main clock enable pulse |
| aux_tick_o | output | 1 | Auxiliary clock enable pulse |

## Verification
A main or auxiliary pulse appears one cycle after the source tick that closes its period. A sub-main pulse appears one cycle later still. A new select code passes through a holding register, and the divider can adopt it only at a boundary, so an idle divider needs two cycles after an input change. The bench therefore settles the configuration for four idle cycles before it starts the source ticks. It counts pulses for six idle cycles after the last tick, so that even the last sub-main pulse is counted. In the boundary test, each sample is taken at the falling edge following the rising edge that handled the tick. Pulse n is then expected exactly one sample after tick n-1.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;

  localparam int unsigned AUX_RATIO_W = 11;

  function automatic logic main_sel_ok(input logic [2:0] code);
    return code < 3'd4;
  endfunction

  function automatic logic aux_sel_ok(input logic [1:0] code);
    return code != 2'd3;
  endfunction

  function automatic logic aux_div_ok(input logic [3:0] code);
    return code < 4'd14;
  endfunction

  function automatic logic [AUX_RATIO_W-1:0] aux_ratio(input logic [3:0] code);
    logic [AUX_RATIO_W-1:0] r;
    unique case (code)
      4'd0:    r = 11'd1;
      4'd1:    r = 11'd16;
      4'd2:    r = 11'd32;
      4'd3:    r = 11'd64;
      4'd4:    r = 11'd128;
      4'd5:    r = 11'd256;
      4'd6:    r = 11'd384;
      4'd7:    r = 11'd512;
      4'd8:    r = 11'd768;
      4'd9:    r = 11'd1024;
      4'd10:   r = 11'd108;
      4'd11:   r = 11'd338;
      4'd12:   r = 11'd414;
      4'd13:   r = 11'd640;
      default: r = 11'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfg_hold.sv
// Keeps the last accepted value of a control field; reserved codes are dropped.
module cfg_hold #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         ok_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (ok_i) q_o <= d_i;
  end

  p_reserved_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_i |=> $stable(q_o));

endmodule

// File: rtl/clk_div_unit.sv
// Source-select plus modulo counter; config adopted only at period boundaries.
module clk_div_unit #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned CNT_W = 7,
  localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int unsigned PAD_N = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             tick_o
);

  logic [PAD_N-1:0] src_pad;
  logic [SEL_W-1:0] act_sel;
  logic [CNT_W-1:0] act_term;
  logic [CNT_W-1:0] cnt;
  logic             src_now;
  logic             wrap;

  generate
    if (PAD_N > NSRC) begin : g_pad
      assign src_pad = {{(PAD_N-NSRC){1'b0}}, src_i};
    end else begin : g_nopad
      assign src_pad = src_i;
    end
  endgenerate

  assign src_now = src_pad[act_sel];
  assign wrap    = src_now && (cnt >= act_term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      act_sel  <= '0;
      act_term <= '0;
      tick_o   <= 1'b0;
    end else begin
      tick_o <= wrap;
      if (wrap) begin
        cnt      <= '0;
        act_sel  <= sel_i;
        act_term <= term_i;
      end else if (src_now) begin
        cnt <= cnt + 1'b1;
      end else if (cnt == '0) begin
        act_sel  <= sel_i;
        act_term <= term_i;
      end
    end
  end

  p_tick_from_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(|src_i));

  p_cfg_at_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_term) |-> (tick_o || $past(cnt) == '0));

  p_sel_at_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_sel) |-> (tick_o || $past(cnt) == '0));

endmodule

// File: rtl/clk_tree_gen.sv
module clk_tree_gen
  import clk_tree_pkg::*;
#(
  parameter int unsigned MAIN_CODE_W = 3,
  parameter int unsigned SUB_CODE_W  = 2,
  parameter int unsigned AUX_CNT_W   = 10,
  localparam int unsigned MAIN_CNT_W = (1 << MAIN_CODE_W) - 1,
  localparam int unsigned SUB_CNT_W  = (1 << SUB_CODE_W) - 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   loop_tick_i,
  input  logic                   ref32_tick_i,
  input  logic                   xtal_tick_i,
  input  logic                   lf10_tick_i,
  input  logic [2:0]             main_sel_i,
  input  logic [MAIN_CODE_W-1:0] main_div_i,
  input  logic [SUB_CODE_W-1:0]  sub_div_i,
  input  logic                   sub_off_i,
  input  logic [1:0]             aux_sel_i,
  input  logic [3:0]             aux_div_i,
  input  logic                   xtal_fault_i,
  input  logic                   fault_off_i,
  output logic                   main_tick_o,
  output logic                   sub_tick_o,
  output logic                   aux_tick_o
);

  localparam logic [MAIN_CNT_W:0] MAIN_ONE = 1;
  localparam logic [SUB_CNT_W:0]  SUB_ONE  = 1;

  logic [2:0]             main_sel_q;
  logic [1:0]             aux_sel_q;
  logic [3:0]             aux_div_q;
  logic [MAIN_CNT_W:0]    main_pow;
  logic [MAIN_CNT_W-1:0]  main_term;
  logic [SUB_CNT_W:0]     sub_pow;
  logic [SUB_CNT_W-1:0]   sub_term;
  logic [AUX_RATIO_W-1:0] aux_ratio_w;
  logic [AUX_RATIO_W-1:0] aux_term_w;
  logic [AUX_CNT_W-1:0]   aux_term;
  logic [3:0]             main_src;
  logic [2:0]             aux_src;
  logic                   xtal_redirect;
  logic                   sub_raw;

  cfg_hold #(.W(3), .RST_VAL(3'd0)) u_main_sel (
    .clk_i, .rst_ni, .d_i(main_sel_i), .ok_i(main_sel_ok(main_sel_i)), .q_o(main_sel_q)
  );
  cfg_hold #(.W(2), .RST_VAL(2'd0)) u_aux_sel (
    .clk_i, .rst_ni, .d_i(aux_sel_i), .ok_i(aux_sel_ok(aux_sel_i)), .q_o(aux_sel_q)
  );
  cfg_hold #(.W(4), .RST_VAL(4'd0)) u_aux_div (
    .clk_i, .rst_ni, .d_i(aux_div_i), .ok_i(aux_div_ok(aux_div_i)), .q_o(aux_div_q)
  );

  // power-of-two terminal counts: 2^code - 1
  assign main_pow  = MAIN_ONE << main_div_i;
  assign main_term = main_pow[MAIN_CNT_W-1:0] - 1'b1;
  assign sub_pow   = SUB_ONE << sub_div_i;
  assign sub_term  = sub_pow[SUB_CNT_W-1:0] - 1'b1;

  assign aux_ratio_w = aux_ratio(aux_div_q);
  assign aux_term_w  = aux_ratio_w - 1'b1;
  assign aux_term    = aux_term_w[AUX_CNT_W-1:0];

  // fault redirect acts on the source line itself, no boundary wait
  assign xtal_redirect = xtal_fault_i && !fault_off_i;
  assign main_src = {lf10_tick_i, xtal_tick_i, ref32_tick_i, loop_tick_i};
  assign aux_src  = {lf10_tick_i, ref32_tick_i,
                     xtal_redirect ? ref32_tick_i : xtal_tick_i};

  clk_div_unit #(.NSRC(4), .CNT_W(MAIN_CNT_W)) u_main (
    .clk_i, .rst_ni, .src_i(main_src), .sel_i(main_sel_q[1:0]),
    .term_i(main_term), .tick_o(main_tick_o)
  );

  clk_div_unit #(.NSRC(1), .CNT_W(SUB_CNT_W)) u_sub (
    .clk_i, .rst_ni, .src_i(main_tick_o), .sel_i(1'b0),
    .term_i(sub_term), .tick_o(sub_raw)
  );

  clk_div_unit #(.NSRC(3), .CNT_W(AUX_CNT_W)) u_aux (
    .clk_i, .rst_ni, .src_i(aux_src), .sel_i(aux_sel_q),
    .term_i(aux_term), .tick_o(aux_tick_o)
  );

  assign sub_tick_o = sub_raw && !sub_off_i;

  p_sub_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_off_i |-> !sub_tick_o);

  p_sub_after_main_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_tick_o |-> $past(main_tick_o));

  p_main_sel_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_sel_q < 3'd4);

endmodule

// File: tb/clk_tree_gen_test.sv
`timescale 1ns/1ps
module clk_tree_gen_test;

  localparam int W    = 4096;
  localparam int TAIL = 6;
  localparam int NVEC = 17;

  typedef struct packed {
    logic [2:0]  msel;
    logic [2:0]  mdiv;
    logic [1:0]  sdiv;
    logic        soff;
    logic [1:0]  asel;
    logic [3:0]  adiv;
    logic        flt;
    logic        foff;
    logic [15:0] mk;  // expected main source period in cycles
    logic [15:0] mr;  // expected main ratio
    logic [15:0] sr;  // expected sub ratio, 0 = gated off
    logic [15:0] ak;  // expected aux source period
    logic [15:0] ar;  // expected aux ratio
  } vec_t;

  // source periods: loop 1, ref32 2, crystal 3, 10 kHz 5
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd0, 2'd0, 1'b0, 2'd1, 4'd0,  1'b0, 1'b0, 16'd1, 16'd1,   16'd1, 16'd2, 16'd1},
    '{3'd1, 3'd1, 2'd1, 1'b0, 2'd0, 4'd1,  1'b0, 1'b0, 16'd2, 16'd2,   16'd2, 16'd3, 16'd16},
    '{3'd2, 3'd3, 2'd3, 1'b0, 2'd2, 4'd2,  1'b0, 1'b0, 16'd3, 16'd8,   16'd8, 16'd5, 16'd32},
    '{3'd3, 3'd2, 2'd2, 1'b1, 2'd1, 4'd3,  1'b0, 1'b0, 16'd5, 16'd4,   16'd0, 16'd2, 16'd64},
    '{3'd0, 3'd7, 2'd0, 1'b0, 2'd1, 4'd4,  1'b0, 1'b0, 16'd1, 16'd128, 16'd1, 16'd2, 16'd128},
    '{3'd0, 3'd6, 2'd3, 1'b0, 2'd1, 4'd5,  1'b0, 1'b0, 16'd1, 16'd64,  16'd8, 16'd2, 16'd256},
    '{3'd0, 3'd4, 2'd0, 1'b0, 2'd1, 4'd6,  1'b0, 1'b0, 16'd1, 16'd16,  16'd1, 16'd2, 16'd384},
    '{3'd0, 3'd5, 2'd1, 1'b0, 2'd1, 4'd7,  1'b0, 1'b0, 16'd1, 16'd32,  16'd2, 16'd2, 16'd512},
    '{3'd0, 3'd0, 2'd0, 1'b0, 2'd1, 4'd8,  1'b0, 1'b0, 16'd1, 16'd1,   16'd1, 16'd2, 16'd768},
    '{3'd1, 3'd0, 2'd0, 1'b0, 2'd1, 4'd9,  1'b0, 1'b0, 16'd2, 16'd1,   16'd1, 16'd2, 16'd1024},
    '{3'd2, 3'd0, 2'd1, 1'b0, 2'd1, 4'd10, 1'b0, 1'b0, 16'd3, 16'd1,   16'd2, 16'd2, 16'd108},
    '{3'd3, 3'd0, 2'd2, 1'b0, 2'd1, 4'd11, 1'b0, 1'b0, 16'd5, 16'd1,   16'd4, 16'd2, 16'd338},
    '{3'd0, 3'd1, 2'd3, 1'b0, 2'd1, 4'd12, 1'b0, 1'b0, 16'd1, 16'd2,   16'd8, 16'd2, 16'd414},
    '{3'd1, 3'd1, 2'd0, 1'b0, 2'd1, 4'd13, 1'b0, 1'b0, 16'd2, 16'd2,   16'd1, 16'd2, 16'd640},
    '{3'd2, 3'd0, 2'd0, 1'b0, 2'd0, 4'd0,  1'b1, 1'b0, 16'd3, 16'd1,   16'd1, 16'd2, 16'd1},
    '{3'd0, 3'd0, 2'd0, 1'b0, 2'd0, 4'd0,  1'b1, 1'b1, 16'd1, 16'd1,   16'd1, 16'd3, 16'd1},
    '{3'd0, 3'd0, 2'd0, 1'b0, 2'd2, 4'd0,  1'b1, 1'b0, 16'd1, 16'd1,   16'd1, 16'd5, 16'd1}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic loop_tick_i = 0, ref32_tick_i = 0, xtal_tick_i = 0, lf10_tick_i = 0;
  logic [2:0] main_sel_i = '0;
  logic [2:0] main_div_i = '0;
  logic [1:0] sub_div_i = '0;
  logic       sub_off_i = 0;
  logic [1:0] aux_sel_i = '0;
  logic [3:0] aux_div_i = '0;
  logic       xtal_fault_i = 0, fault_off_i = 0;
  logic       main_tick_o, sub_tick_o, aux_tick_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  clk_tree_gen uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_src(input int ph);
    loop_tick_i  = (ph >= 0);
    ref32_tick_i = (ph >= 0) && (ph % 2 == 0);
    xtal_tick_i  = (ph >= 0) && (ph % 3 == 0);
    lf10_tick_i  = (ph >= 0) && (ph % 5 == 0);
  endtask

  task automatic set_cfg(input vec_t v);
    main_sel_i = v.msel; main_div_i = v.mdiv; sub_div_i = v.sdiv; sub_off_i = v.soff;
    aux_sel_i = v.asel; aux_div_i = v.adiv; xtal_fault_i = v.flt; fault_off_i = v.foff;
  endtask

  task automatic do_reset();
    drive_src(-1);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic run_window(output int mc, output int sc, output int ac, output int dbl);
    logic prev_a, prev_m;
    mc = 0; sc = 0; ac = 0; dbl = 0; prev_a = 0; prev_m = 0;
    for (int i = 0; i < W + TAIL; i++) begin
      @(negedge clk_i);
      mc += int'(main_tick_o);
      sc += int'(sub_tick_o);
      ac += int'(aux_tick_o);
      if (aux_tick_o && prev_a) dbl++;
      prev_a = aux_tick_o;
      prev_m = main_tick_o;
      drive_src(i < W ? i : -1);
    end
  endtask

  function automatic int ticks_in(input int k);
    return (W + k - 1) / k;
  endfunction

  initial begin
    int mc, sc, ac, dbl, em, es, ea;
    int hits;
    vec_t v;
    // R10: reset state
    drive_src(-1);
    repeat (2) @(negedge clk_i);
    check("R10 reset outputs", int'({main_tick_o, sub_tick_o, aux_tick_o}), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R10 idle outputs", int'({main_tick_o, sub_tick_o, aux_tick_o}), 0);

    // table walk: R1 R2 main, R3 R4 sub, R5 R6 R7 aux
    for (int n = 0; n < NVEC; n++) begin
      v = VECS[n];
      set_cfg(v);
      do_reset();
      run_window(mc, sc, ac, dbl);
      em = ticks_in(int'(v.mk)) / int'(v.mr);
      es = (v.sr == 0) ? 0 : em / int'(v.sr);
      ea = ticks_in(int'(v.ak)) / int'(v.ar);
      check($sformatf("R1/R2 main vec %0d", n), mc, em);
      check($sformatf("%s sub vec %0d", v.soff ? "R4" : "R3", n), sc, es);
      check($sformatf("%s aux vec %0d", v.flt ? "R7" : "R6", n), ac, ea);
      check($sformatf("R10 aux single-cycle vec %0d", n), dbl, 0);
    end

    // R8: reserved codes keep the prior valid fields (R1, R5 reserved values)
    main_sel_i = 3'd2; main_div_i = 3'd0; sub_div_i = 2'd0; sub_off_i = 0;
    aux_sel_i = 2'd2; aux_div_i = 4'd1; xtal_fault_i = 0; fault_off_i = 0;
    do_reset();
    main_sel_i = 3'd5; aux_sel_i = 2'd3; aux_div_i = 4'd15;
    repeat (4) @(negedge clk_i);
    run_window(mc, sc, ac, dbl);
    check("R8 main reserved sel", mc, ticks_in(3));
    check("R8 aux reserved sel/div", ac, ticks_in(5) / 16);
    aux_div_i = 4'd14;
    repeat (4) @(negedge clk_i);
    run_window(mc, sc, ac, dbl);
    check("R8 aux reserved div 14", ac, ticks_in(5) / 16);

    // R9: change /8 -> /1 mid-period; first pulse still after 8 ticks
    main_sel_i = 3'd0; main_div_i = 3'd3; aux_sel_i = 2'd1; aux_div_i = 4'd0;
    do_reset();
    hits = 0;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk_i);
      if (i >= 1 && i <= 7) hits += int'(main_tick_o);
      if (i >= 8) check($sformatf("R9 main pulse sample %0d", i), int'(main_tick_o), 1);
      if (i == 3) main_div_i = 3'd0;
      loop_tick_i = (i < 10);
    end
    check("R9 no early pulse", hits, 0);
    drive_src(-1);

    // R4 live gating with sub running
    main_div_i = 3'd0; sub_div_i = 2'd0; sub_off_i = 1'b0;
    do_reset();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      loop_tick_i = 1'b1;
      if (i == 3) sub_off_i = 1'b1;
    end
    @(negedge clk_i);
    check("R4 sub gated live", int'(sub_tick_o), 0);
    check("R3 main still running", int'(main_tick_o), 1);
    drive_src(-1);
    sub_off_i = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule